// File: doc/BRIEF.md
# UART Transmit Path with Selectable Interrupt and Break

This block serializes bytes onto an asynchronous serial line. Words from the write port are held in a four-entry queue. A frame register takes them one at a time and shifts each out as a start bit, eight data bits and a stop bit. Bit timing comes from an external single-cycle baud tick, so the block contains no rate divider. When the line is idle, a queued word starts straight away, and the first start bit lasts until the next tick.

Each time a word moves from the queue into the frame register, the block can raise a one-cycle interrupt. With the mode input low, every move raises it. With the mode input high, only a move that leaves the queue empty raises it. That gives a producer the choice between refilling word by word and refilling in bursts.

A break input holds the line low and aborts any frame in progress. While break is held, nothing moves out of the queue, so a break never raises an interrupt. After release, the line stays high until at least the next baud tick, which forms the stop level before the next start bit.

Top module: `uart_tx`

## Requirements
- R1: After reset, `tx` is 1, `irq` is 0 and `full` is 0.
- R2: Each frame on `tx` is one start bit at 0, then eight data bits with bit 0 first, then one stop bit at 1. Every bit after the start bit lasts exactly one `baud_tick` period.
- R3: The queue holds 4 words, and `full` is 1 while it holds 4. A write while `full` is 1 is dropped and is never sent.
- R4: If a word is queued when a stop bit ends, its start bit begins in the same clock, so frames follow each other with no idle gap.
- R5: With `irq_mode` = 0, `irq` pulses once for every word moved from the queue into the frame register.
- R6: With `irq_mode` = 1, `irq` pulses only for a move that leaves the queue empty. A write accepted in the same clock as the move counts as leaving it non-empty.
- R7: `irq` is high for exactly one clock per event, one clock after the move.
- R8: While `brk` is 1, `tx` is 0, any frame in progress is abandoned, no word leaves the queue and `irq` stays 0.
- R9: When `brk` falls, `tx` is 1 at once and no new frame starts before the first `baud_tick` after the release has passed.
- R10: A change of `irq_mode` while frames are being sent applies from the next move onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 8 | Byte to queue |
| full | output | 1 | Queue holds four words |
| baud_tick | input | 1 | One-clock pulse per bit period |
| irq_mode | input | 1 | 0: interrupt per move, 1: interrupt when the queue empties |
| brk | input | 1 | Break: force the line low |
| tx | output | 1 | Serial line, idles high |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
The properties assume that `baud_tick` is a single-clock pulse, that `brk` is driven low throughout reset, and that inputs change only between clock edges. The bench drives every input at the falling edge and spaces ticks four clocks apart. Break is held for sixteen ticks, which is longer than the thirteen needed for a valid break. The bench never writes while it expects a frame boundary to carry a mode change, so the clock in which a move happens is known.

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              baud_tick,
  input  logic              irq_mode,
  input  logic              brk,
  output logic              tx,
  output logic              irq
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NBITS = DATA_W + 2;
  localparam int BW    = $clog2(NBITS);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);
  localparam logic [CW-1:0] CONE  = CW'(1);
  localparam logic [AW-1:0] ALAST = AW'(DEPTH - 1);
  localparam logic [BW-1:0] BLAST = BW'(NBITS - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rp, wp;
  logic [CW-1:0]     count;
  logic [NBITS-1:0]  frame;
  logic [BW-1:0]     bitn;
  logic              busy, hold;
  logic              push, ld, last;

  assign full = (count == CFULL);
  assign push = wr_en && !full;
  assign last = (bitn == BLAST);
  assign ld   = (count != '0) && !brk && !hold && (!busy || (baud_tick && last));
  assign tx   = brk ? 1'b0 : (busy ? frame[0] : 1'b1);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == ALAST) ? '0 : wp + 1'b1;
      if (ld)   rp <= (rp == ALAST) ? '0 : rp + 1'b1;
      if (push && !ld)      count <= count + 1'b1;
      else if (ld && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      hold  <= 1'b0;
      bitn  <= '0;
      frame <= '1;
      irq   <= 1'b0;
    end else begin
      irq <= ld && (!irq_mode || (count == CONE && !push));
      if (brk)            hold <= 1'b1;
      else if (baud_tick) hold <= 1'b0;
      if (brk) begin
        busy <= 1'b0;
      end else if (ld) begin
        busy  <= 1'b1;
        bitn  <= '0;
        frame <= {1'b1, mem[rp], 1'b0};
      end else if (busy && baud_tick) begin
        if (last) busy <= 1'b0;
        else begin
          bitn  <= bitn + 1'b1;
          frame <= {1'b1, frame[NBITS-1:1]};
        end
      end
    end
  end
endmodule

// File: rtl/uart_tx_sva.sv
module uart_tx_sva #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          full,
  input logic          brk,
  input logic          tx,
  input logic          irq,
  input logic [CW-1:0] count
);
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R7
  AST_BRK_LOW: assert property (@(posedge clk) disable iff (!rst_n) brk |-> !tx); // R8
  AST_BRK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n) brk |=> !irq); // R8
  AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $fell(brk) |-> tx); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH)); // R3
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (full && wr_en) |=> count <= $past(count)); // R3
endmodule

bind uart_tx uart_tx_sva #(.DEPTH(DEPTH), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .full(full),
  .brk(brk), .tx(tx), .irq(irq), .count(count)
);

// File: tb/uart_tx_test.sv
module uart_tx_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, baud_tick = 1'b0;
  logic irq_mode = 1'b0, brk = 1'b0;
  logic [7:0] wr_data = '0;
  logic full, tx, irq;
  int nchk = 0, nfail = 0;
  int cyc = 0, irqn = 0, rxn = 0, stoperr = 0;
  logic [1:0] tickc = '0;
  logic [7:0] rxq [64];
  int rxt [64];
  logic act = 1'b0;
  int bi = 0;
  logic [7:0] sh = '0;

  localparam logic [8:0] VEC [8] = '{
    {1'b0, 8'h55}, {1'b1, 8'hA3}, {1'b0, 8'h00}, {1'b1, 8'hFF},
    {1'b0, 8'h01}, {1'b1, 8'h80}, {1'b0, 8'h3C}, {1'b1, 8'hC5}};

  uart_tx uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .baud_tick(baud_tick), .irq_mode(irq_mode), .brk(brk), .tx(tx), .irq(irq));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    logic t;
    t = (tickc == 2'd3);
    tickc <= tickc + 2'd1;
    baud_tick <= t;
    cyc = cyc + 1;
    if (irq) irqn = irqn + 1;
    if (brk) act = 1'b0;
    else if (t) begin
      if (!act) begin
        if (!tx) begin act = 1'b1; bi = 0; end
      end else if (bi < 8) begin
        sh[bi] = tx; bi = bi + 1;
      end else begin
        act = 1'b0;
        if (!tx) stoperr = stoperr + 1;
        if (rxn < 64) begin rxq[rxn] = sh; rxt[rxn] = cyc; end
        rxn = rxn + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    for (int i = 0; i < 3000 && rxn < n; i++) @(negedge clk);
    check(rxn >= n, "R2 frame arrival", rxn, n);
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual 0 expected 1");
    finish_run();
  end

  initial begin
    int r0, i0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx == 1'b1, "R1 tx idle", tx, 1);
    check(irq == 1'b0, "R1 irq idle", irq, 0);
    check(full == 1'b0, "R1 full clear", full, 0);

    for (int v = 0; v < 8; v++) begin
      irq_mode = VEC[v][8];
      r0 = rxn; i0 = irqn;
      push(VEC[v][7:0]);
      wait_rx(r0 + 1);
      settle();
      check(rxq[r0] == VEC[v][7:0], "R2 data", rxq[r0], VEC[v][7:0]);
      check(irqn - i0 == 1, VEC[v][8] ? "R6 single word" : "R5 single word", irqn - i0, 1);
    end

    // R5, R4, R7 burst with interrupt per move
    irq_mode = 1'b0; r0 = rxn; i0 = irqn;
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h11;
    @(negedge clk); wr_data = 8'h22;
    @(negedge clk); wr_data = 8'h33;
    @(negedge clk); wr_en = 1'b0;
    wait_rx(r0 + 3); settle();
    check(irqn - i0 == 3, "R5 R7 burst pulses", irqn - i0, 3);
    check(rxq[r0+2] == 8'h33 && rxq[r0+1] == 8'h22, "R2 order", rxq[r0+2], 8'h33);
    check(rxt[r0+2] - rxt[r0] == 80, "R4 no gap", rxt[r0+2] - rxt[r0], 80);

    // R6 burst with interrupt on empty
    irq_mode = 1'b1; r0 = rxn; i0 = irqn;
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h44;
    @(negedge clk); wr_data = 8'h55;
    @(negedge clk); wr_data = 8'h66;
    @(negedge clk); wr_en = 1'b0;
    wait_rx(r0 + 3); settle();
    check(irqn - i0 == 1, "R6 burst pulses", irqn - i0, 1);

    // R10 mode switched after the first move
    irq_mode = 1'b0; r0 = rxn; i0 = irqn;
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h77;
    @(negedge clk); wr_data = 8'h88;
    @(negedge clk); wr_data = 8'h99;
    @(negedge clk); wr_en = 1'b0;
    for (int i = 0; i < 100 && irqn == i0; i++) @(negedge clk);
    check(irq == 1'b0, "R7 pulse width", irq, 0);
    irq_mode = 1'b1;
    wait_rx(r0 + 3); settle();
    check(irqn - i0 == 2, "R10 mode change", irqn - i0, 2);

    // R3, R8, R9 queue filled during break
    r0 = rxn; i0 = irqn;
    @(negedge clk); brk = 1'b1;
    for (int k = 0; k < 6; k++) push(8'hA0 + 8'(k));
    check(full == 1'b1, "R3 full", full, 1);
    repeat (64) begin
      @(negedge clk);
      if (tx !== 1'b0) check(1'b0, "R8 line low", tx, 0);
    end
    check(tx == 1'b0, "R8 line low", tx, 0);
    check(irqn == i0 && rxn == r0, "R8 no move", irqn - i0, 0);
    brk = 1'b0;
    #1 check(tx == 1'b1, "R9 release high", tx, 1);
    @(negedge clk); check(tx == 1'b1, "R9 stop level", tx, 1);
    wait_rx(r0 + 4);
    repeat (200) @(negedge clk);
    check(rxn - r0 == 4, "R3 drops extra", rxn - r0, 4);
    check(rxq[r0] == 8'hA0 && rxq[r0+3] == 8'hA3, "R3 first four kept", rxq[r0+3], 8'hA3);
    check(full == 1'b0, "R3 drained", full, 0);

    // R8 break aborts a frame in progress
    irq_mode = 1'b0; r0 = rxn;
    push(8'h5A);
    repeat (14) @(negedge clk);
    i0 = irqn;
    brk = 1'b1;
    #1 check(tx == 1'b0, "R8 override", tx, 0);
    repeat (64) @(negedge clk);
    brk = 1'b0;
    repeat (120) @(negedge clk);
    check(tx == 1'b1 && rxn == r0, "R8 frame abandoned", rxn - r0, 0);
    check(irqn == i0, "R8 no interrupt", irqn - i0, 0);

    check(stoperr == 0, "R2 stop bits", stoperr, 0);
    finish_run();
  end
endmodule